// File: doc/BRIEF.md
# CSMA/CA Deferral and Backoff Timer

This block decides when a wireless MAC may start a transmission. Once armed, it waits for the medium to stay idle for a deferral interval. That interval is a short inter-frame wait after a good reception, or the longer extended wait after an errored one. It then counts down a programmed number of backoff slots and raises a single-cycle transmit grant when the count runs out. All durations are given in 100 ns units, and time advances only on a tick-enable input that pulses once every 100 ns.

The short deferral is calibrated. The programmed value is shortened by a fixed number of ticks (`CAL_TICKS`, the sum of the receive-path delay and the receive-to-transmit turnaround), so the grant lands early enough that energy reaches the air on time. If the medium turns busy during the slot countdown, the remaining count is frozen. The block then goes back to deferral, and the count resumes only after a complete fresh deferral on an idle medium. An immediate-start control skips the first deferral. A synchronous reset or a backoff reset drops any pending backoff.

FSM states: `ST_IDLE` (waiting for `start`), `ST_DEFER` (counting the deferral on an idle medium), `ST_COUNT` (counting backoff slots) and `ST_GRANT` (one-cycle grant). The transitions are:
- IDLE→DEFER on `start` without `start_now`.
- IDLE→COUNT on `start` with `start_now`.
- DEFER→DEFER restart when the medium is busy.
- DEFER→COUNT when the deferral completes.
- COUNT→DEFER when the medium is busy.
- COUNT→GRANT when the final slot ends, or on entry with zero slots.
- GRANT→IDLE always.
- Any state→IDLE on `rst` or `bo_reset`.

Top module: `csma_backoff_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle, `slots_left` becomes 0 and `tx_permit` is 0.
- R2: With `last_rx_err`=0, the deferral lasts `difs_len - CAL_TICKS` idle ticks (CAL_TICKS=20 by default). If `difs_len <= CAL_TICKS`, the deferral lasts 1 tick.
- R3: With `last_rx_err`=1, the deferral lasts `eifs_len` idle ticks, and a value of 0 counts as 1 tick.
- R4: Each backoff slot lasts `slot_len` idle ticks, and a value of 0 counts as 1 tick. `slots_left` drops by one at the end of each slot and never wraps below 0.
- R5: `tx_permit` is high for exactly one cycle, in the cycle after the last slot ends. With `slot_count`=0, it is high in the cycle after the countdown state is entered. The block then returns to idle.
- R6: `start` together with `start_now`=1 enters the slot countdown directly, with no deferral.
- R7: While the medium is busy in the countdown, `slots_left` holds its value. The countdown resumes only after a full fresh deferral on an idle medium.
- R8: A busy medium during deferral restarts the deferral from zero.
- R9: Neither the deferral nor the slot timing advances in a cycle where `tick` is 0.
- R10: `bo_reset` clears `slots_left` to 0 and returns the block to idle with no grant.
- R11: `start` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 100 ns time-base enable |
| slot_len | input | 10 | Slot duration in ticks |
| difs_len | input | 10 | Short deferral before calibration, in ticks |
| eifs_len | input | 16 | Extended deferral after an errored frame, in ticks |
| slot_count | input | 16 | Backoff slots loaded on start |
| last_rx_err | input | 1 | 1 selects the extended deferral |
| medium_idle | input | 1 | 1 while the medium is idle |
| start | input | 1 | Arm a backoff (used only in idle) |
| start_now | input | 1 | With start: skip the first deferral |
| bo_reset | input | 1 | Drop the pending backoff |
| tx_permit | output | 1 | One-cycle transmit grant |
| slots_left | output | 16 | Remaining backoff slots |

## Verification
With `tick` held high, a start accepted at edge E0 raises `tx_permit` after edge E0+D+N·S. Here D is the effective deferral in ticks (0 with `start_now`), N is the slot count and S is the effective slot length; the N=0 case completes at E0+D+1. `slots_left` changes on the edge that ends each slot, and a busy medium is seen on the next edge. The bench drives every input on the falling edge. It counts falling edges from the accepting edge until the grant is seen and compares that count with the computed latency. It then samples one more falling edge to confirm that the grant lasted a single cycle. Frozen and cleared counts are read on the falling edge that follows the edge that should have acted.

// File: rtl/bo_pkg.sv
package bo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_COUNT = 2'd2,
        ST_GRANT = 2'd3
    } bo_state_e;
endpackage

// File: rtl/bo_interval_timer.sv
// Counts enabled ticks up to a programmed length; done marks the final tick.
module bo_interval_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W:0]   nxt;

    assign nxt  = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    // A length of zero behaves as one tick.
    assign done = advance && (nxt >= {1'b0, len});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= done ? '0 : nxt[W-1:0];
        end
    end
endmodule

// File: rtl/bo_slot_counter.sv
// Holds the remaining backoff slot count.
module bo_slot_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] remaining,
    output logic         is_zero,
    output logic         is_one
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec) begin
            remaining <= remaining - {{(W-1){1'b0}}, 1'b1};
        end
    end

    assign is_zero = (remaining == '0);
    assign is_one  = (remaining == {{(W-1){1'b0}}, 1'b1});

    // R4: the controller never asks for a decrement from zero
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        dec |-> (remaining != '0));
endmodule

// File: rtl/csma_backoff_timer.sv
module csma_backoff_timer
    import bo_pkg::*;
#(
    parameter int SLOT_W    = 10,
    parameter int DIFS_W    = 10,
    parameter int EIFS_W    = 16,
    parameter int CNT_W     = 16,
    parameter int CAL_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [SLOT_W-1:0] slot_len,
    input  logic [DIFS_W-1:0] difs_len,
    input  logic [EIFS_W-1:0] eifs_len,
    input  logic [CNT_W-1:0]  slot_count,
    input  logic              last_rx_err,
    input  logic              medium_idle,
    input  logic              start,
    input  logic              start_now,
    input  logic              bo_reset,
    output logic              tx_permit,
    output logic [CNT_W-1:0]  slots_left
);
    localparam int DEFER_W = (DIFS_W > EIFS_W) ? DIFS_W : EIFS_W;
    localparam logic [DIFS_W-1:0] CAL_V = DIFS_W'(CAL_TICKS);

    bo_state_e state, state_nxt;

    logic               defer_done, slot_done;
    logic               cnt_zero, cnt_one;
    logic               accept;
    logic [DIFS_W-1:0]  difs_cal;
    logic [DEFER_W-1:0] defer_len;

    // Calibrated short deferral, floored at one tick.
    assign difs_cal  = (difs_len > CAL_V) ? (difs_len - CAL_V) : DIFS_W'(1);
    assign defer_len = last_rx_err ? DEFER_W'(eifs_len) : DEFER_W'(difs_cal);
    assign accept    = (state == ST_IDLE) && start && !bo_reset;

    bo_interval_timer #(.W(DEFER_W)) u_defer (
        .clk     (clk),
        .rst     (rst),
        .clear   ((state != ST_DEFER) || !medium_idle),
        .advance ((state == ST_DEFER) && medium_idle && tick),
        .len     (defer_len),
        .done    (defer_done)
    );

    bo_interval_timer #(.W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .clear   ((state != ST_COUNT) || !medium_idle),
        .advance ((state == ST_COUNT) && medium_idle && tick && !cnt_zero),
        .len     (slot_len),
        .done    (slot_done)
    );

    bo_slot_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (bo_reset),
        .load      (accept),
        .load_val  (slot_count),
        .dec       (slot_done && !bo_reset),
        .remaining (slots_left),
        .is_zero   (cnt_zero),
        .is_one    (cnt_one)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nxt = start_now ? ST_COUNT : ST_DEFER;
            end
            ST_DEFER: begin
                if (defer_done) state_nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (cnt_zero)                state_nxt = ST_GRANT;
                else if (!medium_idle)       state_nxt = ST_DEFER;
                else if (slot_done && cnt_one) state_nxt = ST_GRANT;
            end
            ST_GRANT: state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
        if (bo_reset) state_nxt = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // Outputs
    always_comb begin
        tx_permit = (state == ST_GRANT);
    end

    assert_grant_single_R5: assert property (@(posedge clk) disable iff (rst)
        tx_permit |=> !tx_permit);

    assert_immediate_start_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && start_now && !bo_reset) |=> (state == ST_COUNT));

    assert_freeze_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && !medium_idle && !cnt_zero && !bo_reset)
            |=> ($stable(slots_left) && state == ST_DEFER));

    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !tick && !bo_reset) |=> $stable(slots_left));

    assert_bo_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        bo_reset |=> (state == ST_IDLE && slots_left == '0 && !tx_permit));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_GRANT && !tick && !bo_reset) |=> (state != ST_IDLE));
endmodule

// File: tb/csma_backoff_timer_tb_top.sv
module csma_backoff_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst, tick, last_rx_err, medium_idle, start, start_now, bo_reset;
    logic [9:0]  slot_len, difs_len;
    logic [15:0] eifs_len, slot_count;
    logic        tx_permit;
    logic [15:0] slots_left;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    csma_backoff_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .slot_len(slot_len), .difs_len(difs_len),
        .eifs_len(eifs_len), .slot_count(slot_count), .last_rx_err(last_rx_err),
        .medium_idle(medium_idle), .start(start), .start_now(start_now),
        .bo_reset(bo_reset), .tx_permit(tx_permit), .slots_left(slots_left)
    );

    typedef struct packed {
        logic [9:0]  difs;
        logic [15:0] eifs;
        logic [9:0]  slot;
        logic [15:0] n;
        logic        err;
        logic        now;
        logic [31:0] lat;
    } vec_t;

    // Expected latency: deferral ticks (difs-20, floor 1; eifs, floor 1; 0 if now)
    // plus n*slot (slot floor 1), or +1 when n is 0.
    localparam vec_t VECS [8] = '{
        '{10'd30, 16'd0,  10'd5, 16'd3, 1'b0, 1'b0, 32'd25}, // R2 R4
        '{10'd30, 16'd40, 10'd5, 16'd2, 1'b1, 1'b0, 32'd50}, // R3
        '{10'd30, 16'd0,  10'd3, 16'd4, 1'b0, 1'b1, 32'd12}, // R6
        '{10'd30, 16'd0,  10'd5, 16'd0, 1'b0, 1'b0, 32'd11}, // R5 zero slots
        '{10'd30, 16'd0,  10'd5, 16'd0, 1'b0, 1'b1, 32'd1},  // R6 R5
        '{10'd15, 16'd0,  10'd2, 16'd1, 1'b0, 1'b0, 32'd3},  // R2 floor
        '{10'd25, 16'd0,  10'd0, 16'd3, 1'b0, 1'b0, 32'd8},  // R4 zero slot length
        '{10'd30, 16'd0,  10'd4, 16'd1, 1'b1, 1'b0, 32'd5}   // R3 zero eifs
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic arm(input logic [9:0] d, input logic [15:0] e, input logic [9:0] s,
                       input logic [15:0] n, input logic er, input logic nw);
        difs_len = d; eifs_len = e; slot_len = s; slot_count = n;
        last_rx_err = er; start_now = nw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_grant(output int lat);
        lat = 0;
        while (!tx_permit && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_pulse_end(input string tag);
        @(negedge clk);
        check(tx_permit == 1'b0, tag, int'(tx_permit), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        rst = 1'b1; tick = 1'b1; medium_idle = 1'b1; start = 1'b0; start_now = 1'b0;
        bo_reset = 1'b0; last_rx_err = 1'b0; slot_len = 10'd5; difs_len = 10'd30;
        eifs_len = 16'd40; slot_count = 16'd0;
        repeat (3) @(negedge clk);
        check(tx_permit == 1'b0, "R1 reset grant", int'(tx_permit), 0);
        check(slots_left == 16'd0, "R1 reset count", int'(slots_left), 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            arm(VECS[i].difs, VECS[i].eifs, VECS[i].slot, VECS[i].n, VECS[i].err, VECS[i].now);
            wait_grant(lat);
            check(lat == int'(VECS[i].lat), $sformatf("R5 latency row %0d", i), lat, int'(VECS[i].lat));
            check_pulse_end("R5 single pulse");
            repeat (2) @(negedge clk);
        end

        // R7 freeze on busy, R11 start ignored while busy
        arm(10'd30, 16'd0, 10'd5, 16'd4, 1'b0, 1'b1);
        repeat (6) @(negedge clk);
        check(slots_left == 16'd3, "R4 decrement", int'(slots_left), 3);
        medium_idle = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (k == 5) begin
                slot_count = 16'd9; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (slots_left != 16'd3 || tx_permit) begin
                check(1'b0, "R7 frozen count", int'(slots_left), 3);
            end
        end
        start = 1'b0;
        check(slots_left == 16'd3, "R11 start ignored", int'(slots_left), 3);
        medium_idle = 1'b1;
        wait_grant(lat);
        check(lat == 25, "R7 resume after fresh deferral", lat, 25);
        check_pulse_end("R5 single pulse");

        // R8 busy during deferral restarts it
        arm(10'd30, 16'd0, 10'd5, 16'd1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        medium_idle = 1'b0;
        @(negedge clk);
        medium_idle = 1'b1;
        wait_grant(lat);
        check(lat == 15, "R8 deferral restart", lat, 15);
        @(negedge clk);

        // R9 no tick, no progress
        tick = 1'b0;
        arm(10'd30, 16'd0, 10'd5, 16'd2, 1'b0, 1'b0);
        lat = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (tx_permit) lat++;
        end
        check(lat == 0 && slots_left == 16'd2, "R9 frozen without tick", int'(slots_left), 2);
        tick = 1'b1;
        wait_grant(lat);
        check(lat == 20, "R9 resume with tick", lat, 20);
        @(negedge clk);

        // R10 backoff reset
        arm(10'd30, 16'd0, 10'd5, 16'd5, 1'b0, 1'b1);
        repeat (7) @(negedge clk);
        bo_reset = 1'b1;
        @(negedge clk);
        bo_reset = 1'b0;
        check(slots_left == 16'd0, "R10 cleared count", int'(slots_left), 0);
        lat = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (tx_permit) lat++;
        end
        check(lat == 0, "R10 no grant", lat, 0);

        // R1 synchronous reset mid-count
        arm(10'd30, 16'd0, 10'd5, 16'd5, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(slots_left == 16'd0, "R1 reset mid-count", int'(slots_left), 0);
        lat = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (tx_permit) lat++;
        end
        check(lat == 0, "R1 no grant after reset", lat, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule